// File: doc/BRIEF.md
# Scrambled-Map 64-Source Interrupt Controller

This block collects up to 64 on-chip interrupt sources into a pair of 32-bit register banks, a high bank and a low bank. Each bank has an enable (mask) register and a pending register. The source number does not pick its bit in a simple arithmetic way. A fixed scrambled table places every source at a bank and a bit position. Software reaches the block through a small word-addressed register bus.

Each source has a two-bit sense setting. The choices are level low, level high, falling edge and rising edge. Inputs pass through a two-flop synchronizer, then a detected event latches the matching pending bit. Software clears a pending bit by writing a 1 to it. The block reports the lowest-numbered enabled pending source as a 6-bit code in the top bits of a read-only vector word, where 0 means nothing is active. It also drives one request line to the CPU.

Top module: `scr_intc`

## Requirements
- R1: On reset, both mask registers, both pending registers and all sense words are zero, the vector word reads 0 and `cpu_irq_o` is low.
- R2: Register map (word address on `bus_addr_i`): 0 mask high, 1 mask low, 2 pending high, 3 pending low, 4 vector (read only), 5..8 sense words. Source v sits at: v=1..15 low bank bit 16-v; v=16,17,18 high bank bits 2,1,0; v=19..30 high bank bit 33-v; v=31 high bank bit 0; v=32..47 low bank bit 63-v; v=48..63 high bank bit v-32.
- R3: A mask bit of 1 lets its pending bit reach the vector and `cpu_irq_o`, and a 0 blocks it. Mask registers read back exactly what was last written and change only on a write to their own address.
- R4: Writing a 1 to a pending bit clears it, and writing 0 leaves it unchanged. A pending bit falls only through such a write.
- R5: When a source event and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R6: Sense word k (address 5+k) holds sources 16k..16k+15, and source 16k+i uses bits 2i+1:2i. The encodings are 0 level low, 1 level high, 2 falling edge and 3 rising edge. A level source sets pending every cycle it is active. An edge source sets pending only on its edge.
- R7: An input change first shows in the pending register after the third rising clock edge, and not after the second.
- R8: The vector word carries the code in bits 31:26, with bits 25:0 zero. The code is the lowest nonzero source number whose bit is pending and enabled, or 0 when there is none. The bit that sources 18 and 31 share is reported as 18. Reading has no side effect.
- R9: `cpu_irq_o` is high exactly when some pending bit is also enabled, which is exactly when the vector code is nonzero.
- R10: If a level source is still active after it is masked and acknowledged, unmasking it reports it again.
- R11: Input 0 has no effect. Low bank bit 0 and high bank bit 15 never become pending.
- R12: Writes to addresses 9..15 change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | 64 | Raw interrupt inputs, indexed by source number |
| bus_addr_i | input | 4 | Register word address |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| cpu_irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The assertions assume that bus writes are single-cycle strobes with a stable address and data, and that reset is released on a clock edge boundary. The stimulus changes inputs and bus signals only on falling edges, holds each source change for at least three cycles before it samples pending state, and waits for the synchronizer to drain before each acknowledge. Under those limits every pending change can be traced to one event or one write. The edge-sense tests hold a line steady long enough that a missing or doubled edge detection shows up as a wrong pending bit.

// File: rtl/scr_intc_pkg.sv
package scr_intc_pkg;

    localparam int NUM_SRC  = 64;
    localparam int REG_W    = 32;
    localparam int CODE_W   = 6;
    localparam int SENSE_W  = 2;
    localparam int ADDR_W   = 4;
    localparam int SYNC_LEN = 2;
    localparam int SENSE_WORDS = (NUM_SRC * SENSE_W) / REG_W;

    localparam logic [ADDR_W-1:0] A_MASK_HI  = 4'd0;
    localparam logic [ADDR_W-1:0] A_MASK_LO  = 4'd1;
    localparam logic [ADDR_W-1:0] A_PEND_HI  = 4'd2;
    localparam logic [ADDR_W-1:0] A_PEND_LO  = 4'd3;
    localparam logic [ADDR_W-1:0] A_VECTOR   = 4'd4;
    localparam logic [ADDR_W-1:0] A_SENSE0   = 4'd5;

    typedef enum logic [SENSE_W-1:0] {
        SENSE_LVL_LO = 2'd0,
        SENSE_LVL_HI = 2'd1,
        SENSE_FALL   = 2'd2,
        SENSE_RISE   = 2'd3
    } sense_e;

    typedef struct packed {
        logic [NUM_SRC-1:0]         mask;   // [63:32] high bank, [31:0] low bank
        logic [NUM_SRC-1:0]         pend;
        logic [NUM_SRC*SENSE_W-1:0] sense;
    } regs_t;

    // Flat bit index (high bank * 32 + bit) of a source number.
    function automatic logic [CODE_W-1:0] flat_idx(int unsigned v);
        int unsigned hi;
        int unsigned pos;
        if (v < 16) begin
            hi = 0; pos = (16 - v) % 16;
        end else if (v < 19) begin
            hi = 1; pos = 18 - v;
        end else if (v < 31) begin
            hi = 1; pos = 33 - v;
        end else if (v == 31) begin
            hi = 1; pos = 0;
        end else if (v < 48) begin
            hi = 0; pos = 63 - v;
        end else begin
            hi = 1; pos = v - 32;
        end
        return CODE_W'(hi * 32 + pos);
    endfunction

endpackage

// File: rtl/scr_intc_sync.sv
module scr_intc_sync #(
    parameter int WIDTH  = 64,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb begin
        stage_d[0] = raw_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
        prev_d = stage_q[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
            prev_q <= '0;
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= stage_d[s];
            end
            prev_q <= prev_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];
    assign prev_o = prev_q;

endmodule

// File: rtl/scr_intc_sense.sv
module scr_intc_sense
    import scr_intc_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0]         sync_i,
    input  logic [N-1:0]         prev_i,
    input  logic [N*SENSE_W-1:0] sense_i,
    output logic [N-1:0]         set_o    // flat pending-bit set strobes
);

    logic [N-1:0] evt;
    logic         unused_evt0;

    always_comb begin
        for (int v = 0; v < N; v++) begin
            case (sense_e'(sense_i[SENSE_W*v +: SENSE_W]))
                SENSE_LVL_LO: evt[v] = ~sync_i[v];
                SENSE_LVL_HI: evt[v] =  sync_i[v];
                SENSE_FALL:   evt[v] =  prev_i[v] & ~sync_i[v];
                default:      evt[v] = ~prev_i[v] &  sync_i[v];
            endcase
        end
    end

    // Scatter source events onto their scrambled bit positions; source 0 is reserved.
    always_comb begin
        set_o = '0;
        for (int v = 1; v < N; v++) begin
            set_o[flat_idx(v)] = set_o[flat_idx(v)] | evt[v];
        end
    end

    assign unused_evt0 = evt[0];

endmodule

// File: rtl/scr_intc_vec.sv
module scr_intc_vec
    import scr_intc_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0]      active_i,   // flat pending & mask
    output logic [CODE_W-1:0] code_o
);

    // Lowest nonzero source number wins; scan downward so the lowest assignment sticks.
    always_comb begin
        code_o = '0;
        for (int v = N - 1; v >= 1; v--) begin
            if (active_i[flat_idx(v)]) begin
                code_o = CODE_W'(v);
            end
        end
    end

endmodule

// File: rtl/scr_intc.sv
module scr_intc
    import scr_intc_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_SRC-1:0]   irq_src_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic                 bus_we_i,
    input  logic [REG_W-1:0]     bus_wdata_i,
    output logic [REG_W-1:0]     bus_rdata_o,
    output logic                 cpu_irq_o
);

    regs_t st_d, st_q;

    logic [NUM_SRC-1:0] sync_w, prev_w, set_w, clr_w, active_w;
    logic [CODE_W-1:0]  code_w;

    scr_intc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_LEN)) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .raw_i  (irq_src_i),
        .sync_o (sync_w),
        .prev_o (prev_w)
    );

    scr_intc_sense #(.N(NUM_SRC)) i_sense (
        .sync_i  (sync_w),
        .prev_i  (prev_w),
        .sense_i (st_q.sense),
        .set_o   (set_w)
    );

    assign active_w = st_q.pend & st_q.mask;

    scr_intc_vec #(.N(NUM_SRC)) i_vec (
        .active_i (active_w),
        .code_o   (code_w)
    );

    // Write-one-to-clear strobes for both pending banks.
    always_comb begin
        clr_w = '0;
        if (bus_we_i && bus_addr_i == A_PEND_HI) clr_w[NUM_SRC-1:REG_W] = bus_wdata_i;
        if (bus_we_i && bus_addr_i == A_PEND_LO) clr_w[REG_W-1:0]       = bus_wdata_i;
    end

    always_comb begin
        st_d = st_q;
        if (bus_we_i && bus_addr_i == A_MASK_HI) st_d.mask[NUM_SRC-1:REG_W] = bus_wdata_i;
        if (bus_we_i && bus_addr_i == A_MASK_LO) st_d.mask[REG_W-1:0]       = bus_wdata_i;
        for (int k = 0; k < SENSE_WORDS; k++) begin
            if (bus_we_i && bus_addr_i == A_SENSE0 + ADDR_W'(k)) begin
                st_d.sense[REG_W*k +: REG_W] = bus_wdata_i;
            end
        end
        st_d.pend = (st_q.pend & ~clr_w) | set_w;   // a set beats a clear
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_MASK_HI: bus_rdata_o = st_q.mask[NUM_SRC-1:REG_W];
            A_MASK_LO: bus_rdata_o = st_q.mask[REG_W-1:0];
            A_PEND_HI: bus_rdata_o = st_q.pend[NUM_SRC-1:REG_W];
            A_PEND_LO: bus_rdata_o = st_q.pend[REG_W-1:0];
            A_VECTOR:  bus_rdata_o = {code_w, {(REG_W-CODE_W){1'b0}}};
            default: begin
                for (int k = 0; k < SENSE_WORDS; k++) begin
                    if (bus_addr_i == A_SENSE0 + ADDR_W'(k)) begin
                        bus_rdata_o = st_q.sense[REG_W*k +: REG_W];
                    end
                end
            end
        endcase
    end

    assign cpu_irq_o = |active_w;

    // ---------------- assertions ----------------
    assert_irq_code_agree_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpu_irq_o == (code_w != '0));

    assert_code_points_at_live_bit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (code_w != '0) |-> (active_w[flat_idx(int'(code_w))] && code_w != 6'd31));

    assert_reserved_bits_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.pend[0] && !st_q.pend[REG_W + 15]);

    assert_mask_hi_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_we_i && bus_addr_i == A_MASK_HI) |=> $stable(st_q.mask[NUM_SRC-1:REG_W]));

    assert_mask_lo_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_we_i && bus_addr_i == A_MASK_LO) |=> $stable(st_q.mask[REG_W-1:0]));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend_chk
        localparam logic [ADDR_W-1:0] PA = (i >= REG_W) ? A_PEND_HI : A_PEND_LO;
        assert_pend_fall_by_w1c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(st_q.pend[i]) |-> $past(bus_we_i && bus_addr_i == PA && bus_wdata_i[i % REG_W]));
        assert_set_beats_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_w[i] |=> st_q.pend[i]);
    end

endmodule

// File: tb/test_scr_intc.sv
module test_scr_intc;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scr_intc i_scr_intc (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .irq_src_i   (src),
        .bus_addr_i  (addr),
        .bus_we_i    (we),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .cpu_irq_o   (irq)
    );

    // Expected placement, from the requirement text.
    function automatic bit e_hi(int v);
        return (v >= 16 && v <= 31) || v >= 48;
    endfunction
    function automatic int e_pos(int v);
        if (v < 16)  return (v == 0) ? 0 : 16 - v;
        if (v <= 18) return 18 - v;
        if (v <= 30) return 33 - v;
        if (v == 31) return 0;
        if (v < 48)  return 63 - v;
        return v - 32;
    endfunction
    function automatic int e_code(int v);
        return (v == 31) ? 18 : v;
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask
    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask
    task automatic ack_all();
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd3, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, d2;
        tick(3);
        rst_n = 1'b1;
        // R1: state right after release, before any clock edge
        rd(4'd0, d); chk("R1 mask hi", d, 0);
        rd(4'd1, d); chk("R1 mask lo", d, 0);
        rd(4'd2, d); chk("R1 pend hi", d, 0);
        rd(4'd3, d); chk("R1 pend lo", d, 0);
        rd(4'd4, d); chk("R1 vector", d, 0);
        rd(4'd5, d); chk("R1 sense0", d, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R6 default level-low with inputs low; R11 reserved bits; R3 masked off
        tick(3);
        rd(4'd3, d); chk("R6 R11 level-low pend lo", d, 32'hFFFF_FFFE);
        rd(4'd2, d); chk("R6 R11 level-low pend hi", d, 32'hFFFF_7FFF);
        chk("R3 masked irq", {31'b0, irq}, 0);
        rd(4'd4, d); chk("R3 masked vector", d, 0);

        // R6 sense words read back; switch all to level high
        for (int k = 0; k < 4; k++) begin
            wr(4'(5 + k), 32'h5555_5555);
            rd(4'(5 + k), d); chk("R6 sense readback", d, 32'h5555_5555);
        end
        ack_all();
        rd(4'd2, d); chk("R4 ack all hi", d, 0);
        rd(4'd3, d); chk("R4 ack all lo", d, 0);
        wr(4'd0, 32'hFFFF_FFFF); wr(4'd1, 32'hFFFF_FFFF);
        rd(4'd0, d); chk("R3 mask hi readback", d, 32'hFFFF_FFFF);
        rd(4'd1, d); chk("R3 mask lo readback", d, 32'hFFFF_FFFF);

        // R2 R7 R8 R9 R11: single-source sweep
        for (int v = 0; v < 64; v++) begin
            logic [31:0] eh, el;
            eh = '0; el = '0;
            if (v != 0) begin
                if (e_hi(v)) eh[e_pos(v)] = 1'b1; else el[e_pos(v)] = 1'b1;
            end
            src = 64'd1 << v;
            tick(2);
            rd(4'd2, d); chk("R7 not yet hi", d, 0);
            rd(4'd3, d); chk("R7 not yet lo", d, 0);
            tick(1);
            rd(4'd2, d); chk("R2 R11 pend hi", d, eh);
            rd(4'd3, d); chk("R2 R11 pend lo", d, el);
            rd(4'd4, d); chk("R8 vector", d, 32'(e_code(v)) << 26);
            rd(4'd4, d2); chk("R8 reread", d2, d);
            chk("R9 irq", {31'b0, irq}, (v != 0) ? 1 : 0);
            src = '0;
            tick(3);
            ack_all();
            rd(4'd3, d); chk("R4 cleared", d, 0);
        end

        // R8 priority and R3 masking on source pairs
        for (int a = 1; a < 64; a++) begin
            int b, w, o, ew;
            b = ((a * 37) % 63) + 1;
            if (b == a) continue;
            w = (e_code(a) <= e_code(b)) ? a : b;
            o = (w == a) ? b : a;
            src = (64'd1 << a) | (64'd1 << b);
            tick(3);
            rd(4'd4, d); chk("R8 pair priority", d, 32'(e_code(w)) << 26);
            wr(e_hi(w) ? 4'd0 : 4'd1, ~(32'd1 << e_pos(w)));
            ew = (e_hi(o) == e_hi(w) && e_pos(o) == e_pos(w)) ? 0 : e_code(o);
            rd(4'd4, d); chk("R3 mask winner", d, 32'(ew) << 26);
            wr(4'd0, 32'hFFFF_FFFF); wr(4'd1, 32'hFFFF_FFFF);
            src = '0;
            tick(3);
            ack_all();
        end

        // R5 set wins, R4 zero write keeps bit (source 7 -> low bit 9)
        src = 64'd1 << 7;
        tick(3);
        wr(4'd3, 32'h0);
        rd(4'd3, d); chk("R4 zero write", d, 32'h200);
        wr(4'd3, 32'h200);
        rd(4'd3, d); chk("R5 set wins", d, 32'h200);
        src = '0; tick(3); ack_all();
        rd(4'd3, d); chk("R4 clear after drop", d, 0);

        // R10 mask-and-ack with level still active (source 40 -> low bit 23)
        src = 64'd1 << 40;
        tick(3);
        rd(4'd4, d); chk("R10 first report", d, 32'd40 << 26);
        wr(4'd1, ~(32'd1 << 23));
        wr(4'd3, 32'd1 << 23);
        rd(4'd4, d); chk("R10 masked", d, 0);
        chk("R10 irq masked", {31'b0, irq}, 0);
        wr(4'd1, 32'hFFFF_FFFF);
        rd(4'd4, d); chk("R10 reported again", d, 32'd40 << 26);
        chk("R10 irq again", {31'b0, irq}, 1);
        src = '0; tick(3); ack_all();

        // R6 edge senses on source 5 (low bit 11, sense bits 11:10 of word 0)
        wr(4'd5, 32'h5555_5D55);              // rising
        src = 64'd1 << 5; tick(3);
        rd(4'd3, d); chk("R6 rising sets", d, 32'h800);
        ack_all(); tick(2);
        rd(4'd3, d); chk("R6 rising once", d, 0);
        src = '0; tick(3);
        rd(4'd3, d); chk("R6 rising ignores fall", d, 0);
        wr(4'd5, 32'h5555_5955);              // falling
        src = 64'd1 << 5; tick(3);
        rd(4'd3, d); chk("R6 falling ignores rise", d, 0);
        src = '0; tick(3);
        rd(4'd3, d); chk("R6 falling sets", d, 32'h800);
        ack_all();
        wr(4'd5, 32'h5555_5155);              // level low, input low
        tick(1);
        rd(4'd3, d); chk("R6 level low sets", d, 32'h800);
        src = 64'd1 << 5; tick(3); ack_all(); tick(1);
        rd(4'd3, d); chk("R6 level low idle when high", d, 0);
        wr(4'd5, 32'h5555_5555);
        src = '0; tick(3); ack_all();

        // R12 unmapped addresses
        for (int a = 9; a < 16; a++) begin
            wr(4'(a), 32'hFFFF_FFFF);
            rd(4'(a), d); chk("R12 unmapped read", d, 0);
        end
        wr(4'd0, 32'h0);
        for (int a = 9; a < 16; a++) wr(4'(a), 32'hFFFF_FFFF);
        rd(4'd0, d); chk("R12 mask untouched", d, 0);
        rd(4'd5, d); chk("R12 sense untouched", d, 32'h5555_5555);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule